// File: doc/BRIEF.md
# Serial Audio Clock Divider Chain

This block produces all timing for one serial audio port from a single fast peripheral clock. A bit clock is either made inside the block or taken from a pin. Inside the block, a fixed divide-by-8 stage can be switched in, followed by a programmable modulus divider and a final halving stage that gives 50% duty. From a pin, the external bit clock is resynchronised and its rising edges are detected. A bit counter divides the bit clock into words of a selectable length, and a word counter groups the words into frames. The block drives the bit clock to the port pins, a frame sync, a one-cycle strobe at each word start and an optional oversampling clock.

The frame sync can be made inside the block or taken from a pin. With an internal frame sync, every frame starts on its own after the programmed word count. With an external frame sync, counting waits for a rising edge on the pin, and that edge realigns the frame. All configuration inputs are static. A new word length or frame size is loaded only when a frame starts, so a running frame is never cut short. Dropping the enable clears the chain at once.

Top module: `sai_clock_chain`

## Requirements
- R1: The `wl_sel` codes 0 to 7 select 8, 10, 12, 16, 18, 20, 22 and 24 bits per word. `word_strobe` repeats every word-length bit periods.
- R2: The `frame_words` field holds the number of words per frame minus one, so a frame is 1 to 32 words long. With an internal frame sync, a new frame starts every `frame_words`+1 words.
- R3: The internal frame sync goes high with the bit-clock rising edge that starts word 0 of a frame. It stays high for exactly one bit period. `word_strobe` is high for one peripheral clock at the start of every word.
- R4: With `bclk_src`=1, the bit clock has a period of 2·(`pre_mod`+1)·D peripheral clocks at 50% duty, where D is 8 when `pre_range`=1 and 1 otherwise. The first rising edge comes (`pre_mod`+1)·D−1 clocks after the first edge that samples `enable` high.
- R5: With `bclk_src`=0, `bclk_out` follows `ext_bclk` through a two-flop synchroniser, two clocks late. Word timing counts the rising edges of that synchronised pin.
- R6: With `fs_src`=0, `fs_out` follows `ext_fs` two clocks late. No word strobe appears before the first pin edge. A rising edge on the pin starts word 0 at the next bit-clock rising edge.
- R7: `mclk_out` toggles once every D peripheral clocks while the internal bit clock runs and `sysclk_en`=1. Otherwise it is low. Its period divides the frame period evenly.
- R8: A change of word length while running takes effect only at the next frame start.
- R9: One edge after `enable` is sampled low, every output is low and every counter is clear. Enabling again restarts exactly as from reset.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the chain; low clears it |
| bclk_src | input | 1 | 1: internal bit clock (master), 0: from `ext_bclk` |
| fs_src | input | 1 | 1: internal frame sync, 0: from `ext_fs` |
| wl_sel | input | 3 | Word length code (see R1) |
| frame_words | input | DC_W (5) | Words per frame minus one |
| pre_range | input | 1 | Switches in the fixed divide-by-8 stage |
| pre_mod | input | PM_W (8) | Modulus divider value minus one |
| sysclk_en | input | 1 | Drives the oversampling clock out |
| ext_bclk | input | 1 | External bit clock pin |
| ext_fs | input | 1 | External frame sync pin |
| bclk_out | output | 1 | Bit clock to the transmit and receive pins |
| fs_out | output | 1 | Frame sync |
| word_strobe | output | 1 | One-clock pulse at each word start |
| mclk_out | output | 1 | Oversampling clock |

## Verification
A bit or word index that goes wrong shows up at the ports within one word. The next `word_strobe` comes at the wrong place, and the frame sync drifts away from the word that should carry it. A prescaler fault changes the spacing of `bclk_out` edges within one bit period. For that reason, the bench compares every clock cycle against a closed-form timeline instead of sampling only a few points. A configuration loaded at the wrong time can stay hidden for a whole frame. It becomes visible only at the first word after the next frame start, so the directed test looks exactly there.

// File: rtl/sai_clk_pkg.sv
package sai_clk_pkg;

  localparam int WLSEL_W  = 3;
  localparam int BITIDX_W = 5;

  typedef enum logic {
    SRC_PIN      = 1'b0,
    SRC_INTERNAL = 1'b1
  } clk_src_e;

  // Decode of the word length selection into a bit count.
  function automatic logic [BITIDX_W-1:0] wl_bits(input logic [WLSEL_W-1:0] sel);
    case (sel)
      3'd0:    return 5'd8;
      3'd1:    return 5'd10;
      3'd2:    return 5'd12;
      3'd3:    return 5'd16;
      3'd4:    return 5'd18;
      3'd5:    return 5'd20;
      3'd6:    return 5'd22;
      default: return 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/sai_edge_sync.sv
module sai_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic din,
  output logic level,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clear) sh <= '0;
    else            sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sai_prescaler.sv
module sai_prescaler #(
  parameter int PM_W    = 8,
  parameter int PRE_DIV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            psr,
  input  logic [PM_W-1:0] pm,
  output logic            mod_tick,
  output logic            bclk,
  output logic            mclk
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PM_W-1:0]  mod_cnt;
  logic             pre_wrap, pre_tick, mod_wrap;

  assign pre_wrap = (pre_cnt == PRE_W'(PRE_DIV - 1));
  assign pre_tick = run & (psr ? pre_wrap : 1'b1);
  assign mod_wrap = (mod_cnt == pm);
  assign mod_tick = pre_tick & mod_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      mod_cnt <= '0;
      bclk    <= 1'b0;
      mclk    <= 1'b0;
    end else if (!run) begin
      pre_cnt <= '0;
      mod_cnt <= '0;
      bclk    <= 1'b0;
      mclk    <= 1'b0;
    end else begin
      if (psr) pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      else     pre_cnt <= '0;
      if (pre_tick) begin
        mod_cnt <= mod_wrap ? '0 : mod_cnt + 1'b1;
        mclk    <= ~mclk;
      end
      if (mod_tick) bclk <= ~bclk;
    end
  end
endmodule

// File: rtl/sai_frame_counter.sv
module sai_frame_counter
  import sai_clk_pkg::*;
#(
  parameter int DC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                bit_tick,
  input  logic                ext_frame,
  input  logic                pin_rise,
  input  logic [WLSEL_W-1:0]  wl_sel,
  input  logic [DC_W-1:0]     dc_field,
  output logic                word_strobe,
  output logic                fs_int,
  output logic [BITIDX_W-1:0] bit_idx,
  output logic [BITIDX_W-1:0] wl_len,
  output logic [DC_W-1:0]     word_idx,
  output logic [DC_W-1:0]     dc_act
);
  logic               started, fs_pend;
  logic [WLSEL_W-1:0] wl_act;
  logic               last_bit, last_word, pin_frame;
  logic               begin_word, begin_frame;

  assign wl_len    = wl_bits(wl_act);
  assign last_bit  = (bit_idx == wl_len - 5'd1);
  assign last_word = (word_idx == dc_act);
  assign pin_frame = ext_frame & (fs_pend | pin_rise);

  always_comb begin
    begin_word  = 1'b0;
    begin_frame = 1'b0;
    if (bit_tick) begin
      if (ext_frame) begin
        if (pin_frame) begin
          begin_frame = 1'b1;
          begin_word  = 1'b1;
        end else if (started && last_bit) begin
          begin_word = 1'b1;
        end
      end else begin
        if (!started || (last_bit && last_word)) begin
          begin_frame = 1'b1;
          begin_word  = 1'b1;
        end else if (last_bit) begin
          begin_word = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      fs_pend     <= 1'b0;
      fs_int      <= 1'b0;
      word_strobe <= 1'b0;
      bit_idx     <= '0;
      word_idx    <= '0;
      wl_act      <= '0;
      dc_act      <= '0;
    end else if (!run) begin
      started     <= 1'b0;
      fs_pend     <= 1'b0;
      fs_int      <= 1'b0;
      word_strobe <= 1'b0;
      bit_idx     <= '0;
      word_idx    <= '0;
      wl_act      <= '0;
      dc_act      <= '0;
    end else begin
      word_strobe <= begin_word;
      fs_pend     <= ext_frame & (fs_pend | pin_rise) & ~bit_tick;
      if (bit_tick) begin
        if (begin_frame) begin
          started  <= 1'b1;
          bit_idx  <= '0;
          word_idx <= '0;
          wl_act   <= wl_sel;
          dc_act   <= dc_field;
          fs_int   <= 1'b1;
        end else begin
          fs_int <= 1'b0;
          if (started) begin
            if (last_bit) begin
              bit_idx  <= '0;
              word_idx <= last_word ? '0 : word_idx + 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sai_clock_chain.sv
module sai_clock_chain
  import sai_clk_pkg::*;
#(
  parameter int PM_W        = 8,
  parameter int DC_W        = 5,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            bclk_src,
  input  logic            fs_src,
  input  logic [2:0]      wl_sel,
  input  logic [DC_W-1:0] frame_words,
  input  logic            pre_range,
  input  logic [PM_W-1:0] pre_mod,
  input  logic            sysclk_en,
  input  logic            ext_bclk,
  input  logic            ext_fs,
  output logic            bclk_out,
  output logic            fs_out,
  output logic            word_strobe,
  output logic            mclk_out
);
  logic                internal_bclk, internal_fs;
  logic                pre_run, mod_tick, bclk_int, mclk_q;
  logic                bclk_lvl, bclk_rise, fs_lvl, fs_rise;
  logic                bit_tick, fs_int;
  logic [BITIDX_W-1:0] bit_idx, wl_len;
  logic [DC_W-1:0]     word_idx, dc_act;

  assign internal_bclk = (bclk_src == SRC_INTERNAL);
  assign internal_fs   = (fs_src == SRC_INTERNAL);
  assign pre_run       = enable & internal_bclk;

  sai_prescaler #(.PM_W(PM_W), .PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(pre_run), .psr(pre_range), .pm(pre_mod),
    .mod_tick(mod_tick), .bclk(bclk_int), .mclk(mclk_q)
  );

  sai_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .clear(~enable), .din(ext_bclk),
    .level(bclk_lvl), .rise(bclk_rise)
  );

  sai_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .clear(~enable), .din(ext_fs),
    .level(fs_lvl), .rise(fs_rise)
  );

  // rising bit-clock event from the selected source
  assign bit_tick = internal_bclk ? (mod_tick & ~bclk_int) : bclk_rise;

  sai_frame_counter #(.DC_W(DC_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(enable), .bit_tick(bit_tick),
    .ext_frame(~internal_fs), .pin_rise(fs_rise),
    .wl_sel(wl_sel), .dc_field(frame_words),
    .word_strobe(word_strobe), .fs_int(fs_int),
    .bit_idx(bit_idx), .wl_len(wl_len), .word_idx(word_idx), .dc_act(dc_act)
  );

  assign bclk_out = internal_bclk ? bclk_int : bclk_lvl;
  assign fs_out   = internal_fs ? fs_int : fs_lvl;
  assign mclk_out = mclk_q & sysclk_en;
endmodule

// File: rtl/sai_clock_chain_chk.sv
module sai_clock_chain_chk #(
  parameter int DC_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            bclk_src,
  input logic            fs_src,
  input logic            bclk_out,
  input logic            fs_out,
  input logic            word_strobe,
  input logic            mclk_out,
  input logic            mod_tick,
  input logic [4:0]      bit_idx,
  input logic [4:0]      wl_len,
  input logic [DC_W-1:0] word_idx,
  input logic [DC_W-1:0] dc_act
);
  assert_word_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe);

  assert_fs_on_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_src && $rose(fs_out)) |-> word_strobe);

  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk_out && !fs_out && !word_strobe && !mclk_out));

  assert_bit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (bit_idx < wl_len));

  assert_word_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (word_idx <= dc_act));

  assert_bclk_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_src && enable && $past(enable) && !$stable(bclk_out)) |-> $past(mod_tick));
endmodule

bind sai_clock_chain sai_clock_chain_chk #(.DC_W(DC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_src(bclk_src), .fs_src(fs_src),
  .bclk_out(bclk_out), .fs_out(fs_out), .word_strobe(word_strobe), .mclk_out(mclk_out),
  .mod_tick(mod_tick), .bit_idx(bit_idx), .wl_len(wl_len),
  .word_idx(word_idx), .dc_act(dc_act)
);

// File: tb/test_sai_clock_chain.sv
`timescale 1ns/1ps
module test_sai_clock_chain;
  logic       clk = 1'b0;
  logic       rst_n, enable, bclk_src, fs_src, pre_range, sysclk_en, ext_bclk, ext_fs;
  logic [2:0] wl_sel;
  logic [4:0] frame_words;
  logic [7:0] pre_mod;
  logic       bclk_out, fs_out, word_strobe, mclk_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  bit rec_b [400];
  bit rec_w [400];
  bit rec_f [400];
  bit ext_h [400];

  always #10 clk = ~clk;

  sai_clock_chain i_sai_clock_chain (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_src(bclk_src), .fs_src(fs_src),
    .wl_sel(wl_sel), .frame_words(frame_words), .pre_range(pre_range), .pre_mod(pre_mod),
    .sysclk_en(sysclk_en), .ext_bclk(ext_bclk), .ext_fs(ext_fs),
    .bclk_out(bclk_out), .fs_out(fs_out), .word_strobe(word_strobe), .mclk_out(mclk_out)
  );

  // vector: {pre_range, pre_mod[7:0], wl_sel[2:0], frame_words[4:0], sysclk_en}
  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 8'd0, 3'd0, 5'd1,  1'b1},
    {1'b0, 8'd2, 3'd7, 5'd0,  1'b0},
    {1'b1, 8'd0, 3'd2, 5'd3,  1'b1},
    {1'b0, 8'd1, 3'd3, 5'd31, 1'b1},
    {1'b0, 8'd0, 3'd1, 5'd2,  1'b1},
    {1'b0, 8'd0, 3'd4, 5'd0,  1'b0},
    {1'b1, 8'd1, 3'd5, 5'd1,  1'b1},
    {1'b0, 8'd3, 3'd6, 5'd2,  1'b1}
  };

  function automatic int exp_wl(input int code);
    return (code < 3) ? 8 + 2 * code : 10 + 2 * code;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start(input logic ps, input logic [7:0] pm, input logic [2:0] ws,
                       input logic [4:0] dc, input logic sy, input logic bsrc, input logic fsrc);
    @(negedge clk);
    enable = 1'b0; pre_range = ps; pre_mod = pm; wl_sel = ws; frame_words = dc;
    sysclk_en = sy; bclk_src = bsrc; fs_src = fsrc; ext_bclk = 1'b0; ext_fs = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic run_vec(input logic [17:0] v, input int idx);
    int d, p, f, wl, flen, n, t, e, a;
    int bad [4];
    int fa [4];
    int fe [4];
    string nm [4];
    nm[0] = "R4 bclk_out"; nm[1] = "R1 word_strobe"; nm[2] = "R2/R3 fs_out"; nm[3] = "R7 mclk_out";
    for (int i = 0; i < 4; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end
    start(v[17], v[16:9], v[8:6], v[5:1], v[0], 1'b1, 1'b1);
    d    = v[17] ? 8 : 1;
    p    = 2 * (int'(v[16:9]) + 1) * d;
    f    = (int'(v[16:9]) + 1) * d - 1;
    wl   = exp_wl(int'(v[8:6]));
    flen = wl * (int'(v[5:1]) + 1) * p;
    n    = f + 2 * flen + p;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      t = k - f;
      for (int s = 0; s < 4; s++) begin
        case (s)
          0: begin e = (t >= 0 && (t % p) < p / 2) ? 1 : 0; a = int'(bclk_out); end
          1: begin e = (t >= 0 && (t % (wl * p)) == 0) ? 1 : 0; a = int'(word_strobe); end
          2: begin e = (t >= 0 && (t % flen) < p) ? 1 : 0; a = int'(fs_out); end
          default: begin e = (v[0] && (((k + 1) / d) % 2 == 1)) ? 1 : 0; a = int'(mclk_out); end
        endcase
        if (a != e && bad[s] == 0) begin bad[s] = 1; fa[s] = a; fe[s] = e; end
      end
    end
    for (int s = 0; s < 4; s++)
      check(nm[s].substr(0, 1), $sformatf("vector %0d %s", idx, nm[s]), fa[s], fe[s]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int f1, prev, run_len;
    rst_n = 1'b0; enable = 1'b1; bclk_src = 1'b1; fs_src = 1'b1; pre_range = 1'b0;
    pre_mod = 8'd0; wl_sel = 3'd0; frame_words = 5'd1; sysclk_en = 1'b1;
    ext_bclk = 1'b0; ext_fs = 1'b0;
    repeat (4) @(negedge clk);
    // R10: all outputs low in reset
    check("R10", "outputs during reset", int'({bclk_out, fs_out, word_strobe, mclk_out}), 0);
    rst_n = 1'b1; enable = 1'b0;

    // table walk: R1 R2 R3 R4 R7
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v], v);

    // R9: disable mid-run clears, restart as fresh
    start(1'b0, 8'd0, 3'd0, 5'd1, 1'b1, 1'b1, 1'b1);
    repeat (37) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9", "outputs one edge after disable", int'({bclk_out, fs_out, word_strobe, mclk_out}), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R9", "bclk/fs/strobe on first edge after re-enable", int'({bclk_out, fs_out, word_strobe}), 7);

    // R8: word length change mid-frame applies at next frame
    start(1'b0, 8'd0, 3'd0, 5'd1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      rec_w[k] = word_strobe; rec_f[k] = fs_out;
      if (k == 10) wl_sel = 3'd3;
    end
    check("R8", "strobe at old second word (k=16)", int'(rec_w[16]), 1);
    check("R8", "no strobe at old spacing (k=48)", int'(rec_w[48]), 0);
    check("R8", "strobe at new spacing (k=64)", int'(rec_w[64]), 1);
    check("R8", "no frame sync at k=64", int'(rec_f[64]), 0);
    check("R8", "frame sync after new frame (k=96)", int'(rec_f[96]), 1);

    // R5: external bit clock, period 10 clocks
    start(1'b0, 8'd0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rec_b[k] = bclk_out; rec_w[k] = word_strobe; rec_f[k] = fs_out;
      ext_h[k] = ((k % 10) >= 5);
      ext_bclk = ext_h[k];
    end
    begin
      int mism, cnt, bad_gap;
      mism = 0; cnt = 0; bad_gap = 0; prev = -1; run_len = 0;
      for (int k = 2; k < 400; k++) if (rec_b[k] != ext_h[k-2]) mism++;
      check("R5", "bclk_out vs pin delayed two clocks, mismatches", mism, 0);
      for (int k = 0; k < 400; k++) if (rec_w[k]) begin
        if (prev >= 0 && k - prev != 80) bad_gap = k - prev;
        prev = k; cnt++;
      end
      check("R5", "word strobe gap from pin clock (0=ok)", bad_gap, 0);
      check("R5", "word strobes seen >= 3", int'(cnt >= 3), 1);
      for (int k = 0; k < 400; k++) if (rec_f[k] && run_len >= 0) run_len++;
        else if (run_len > 0) break;
      check("R3", "frame sync width with pin clock", run_len, 10);
    end

    // R6: external frame sync with internal bit clock
    start(1'b0, 8'd0, 3'd0, 5'd0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      rec_w[k] = word_strobe; rec_f[k] = fs_out;
      ext_fs = (k >= 40 && k < 44);
    end
    begin
      int early;
      early = 0; f1 = -1;
      for (int k = 0; k < 42; k++) if (rec_w[k]) early++;
      check("R6", "word strobes before pin edge", early, 0);
      check("R6", "fs_out low before sync delay (k=41)", int'(rec_f[41]), 0);
      check("R6", "fs_out follows pin (k=42)", int'(rec_f[42]), 1);
      for (int k = 42; k < 120; k++) if (rec_w[k] && f1 < 0) f1 = k;
      check("R6", "first strobe within one bit after pin edge", int'(f1 >= 43 && f1 <= 46), 1);
      check("R6", "next strobe one word later", int'(f1 >= 0 && rec_w[f1 + 16]), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule